// File: doc/BRIEF.md
# Masked Packed Pair Shuffle Unit

This datapath builds a 512-bit vector of 64-bit elements from two source vectors. Each 128-bit lane holds one pair of elements from each source. Destination element 2k of lane k comes from the first source's pair k, and element 2k+1 comes from the second source's pair k. One immediate bit per destination element chooses the low or the high member of that pair. The elements are copied bit for bit. Floating-point contents such as NaN or denormal patterns are never interpreted, and no exception is raised.

A two-bit mode input picks how the rest of the vector is treated:

- **Legacy two-operand mode** reads the first source from the old destination value.
- **Unmasked three-operand mode** works on the first and second sources.
- **The two masked modes** add per-element writemasking, an optional broadcast of the second source, and zero-filling above the active length.

The result is registered one cycle after a valid strobe.

Top module: `pair_shuffle_unit`

## Requirements
- R1: Destination element 2k takes element 2k+imm[2k] of the first source, and element 2k+1 takes element 2k+imm[2k+1] of the second source. Element e occupies bits [64e+63:64e], so imm bit 0 picks the low member of the pair and imm bit 1 picks the high member.
- R2: `len_i` selects the active length: 0 gives 2 elements (128 bits), 1 gives 4 elements (256 bits), and 2 or 3 gives 8 elements (512 bits). Immediate bits at or above the element count have no effect on the result.
- R3: In the masked modes (`mode_i` 2 or 3) with `bcast_i` set, every element of the second source is replaced by its bits [63:0] before selection. In `mode_i` 0 and 1, `bcast_i` is ignored.
- R4: In a masked mode, an active element whose `mask_i` bit is 1, or any active element while `mask_en_i` is 0, receives the shuffled value.
- R5: In masked-merge mode (`mode_i`=2) with `mask_en_i`=1, an active element whose mask bit is 0 keeps the `old_i` element.
- R6: In masked-zero mode (`mode_i`=3) with `mask_en_i`=1, an active element whose mask bit is 0 becomes zero.
- R7: In the masked modes, all result bits at and above the active length are zero.
- R8: In unmasked three-operand mode (`mode_i`=1), bits above 128 are zero when `len_i`=0, bits above 256 equal `old_i` when `len_i`=1, and all 512 bits are shuffled otherwise. The mask and `mask_en_i` are ignored.
- R9: In legacy mode (`mode_i`=0), the first source is `old_i` and `src1_i` is ignored. The length is 128 bits regardless of `len_i`, bits above 128 equal `old_i`, and the mask and broadcast inputs are ignored.
- R10: `res_o` and `valid_o` update on the clock edge that samples `valid_i`=1. When `valid_i`=0, `valid_o` drops and `res_o` holds. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| valid_i | input | 1 | operands valid this cycle |
| mode_i | input | 2 | 0 legacy, 1 unmasked, 2 masked-merge, 3 masked-zero |
| len_i | input | 2 | active length select |
| bcast_i | input | 1 | broadcast low element of second source |
| mask_en_i | input | 1 | apply writemask (masked modes) |
| mask_i | input | 8 | per-element write mask |
| imm_i | input | 8 | per-element pair select |
| src1_i | input | 512 | first source |
| src2_i | input | 512 | second source |
| old_i | input | 512 | prior destination value |
| valid_o | output | 1 | result valid |
| res_o | output | 512 | registered result |

## Verification
Broadcast and writemasking can act in the same cycle on the same element. In masked-merge or masked-zero mode with `bcast_i` set and a sparse mask, odd elements whose mask bit is set must show the replicated low element of the second source. Cleared elements must show `old_i` or zero instead. Random stimulus hits this mix often, and the bench model replays broadcast, selection, masking and tail handling in that order to judge every element.

// File: rtl/pshuf_pkg.sv
package pshuf_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_PLAIN  = 2'd1,
    MODE_MERGE  = 2'd2,
    MODE_ZERO   = 2'd3
  } shuf_mode_e;
endpackage

// File: rtl/pshuf_ctrl.sv
module pshuf_ctrl
  import pshuf_pkg::*;
#(
  parameter int NUM_ELEM = 8
) (
  input  logic [1:0]          mode_i,
  input  logic [1:0]          len_i,
  output logic [NUM_ELEM-1:0] act_o,
  output logic                tail_keep_o,
  output logic                mask_on_o,
  output logic                bcast_on_o,
  output logic                src1_old_o
);
  localparam int CNT_W = $clog2(NUM_ELEM) + 3;

  shuf_mode_e       mode;
  logic [CNT_W-1:0] cnt;

  assign mode = shuf_mode_e'(mode_i);

  always_comb begin
    if (mode == MODE_LEGACY) cnt = CNT_W'(2);
    else                     cnt = CNT_W'(2) << len_i;
    if (cnt > CNT_W'(NUM_ELEM)) cnt = CNT_W'(NUM_ELEM);
  end

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_act
    assign act_o[e] = (CNT_W'(e) < cnt);
  end

  assign tail_keep_o = (mode == MODE_LEGACY) || (mode == MODE_PLAIN && len_i == 2'd1);
  assign mask_on_o   = mode_i[1];
  assign bcast_on_o  = mode_i[1];
  assign src1_old_o  = (mode == MODE_LEGACY);
endmodule

// File: rtl/pshuf_select.sv
module pshuf_select #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64
) (
  input  logic [NUM_ELEM*ELEM_W-1:0] a_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] b_i,
  input  logic [NUM_ELEM-1:0]        sel_i,
  output logic [NUM_ELEM*ELEM_W-1:0] shuf_o
);
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    localparam int LO = (e / 2) * 2;
    logic [NUM_ELEM*ELEM_W-1:0] src;
    if (e % 2 == 0) begin : g_even
      assign src = a_i;
    end else begin : g_odd
      assign src = b_i;
    end
    assign shuf_o[e*ELEM_W +: ELEM_W] = sel_i[e] ? src[(LO+1)*ELEM_W +: ELEM_W]
                                                 : src[LO*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/pshuf_finish.sv
module pshuf_finish #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64
) (
  input  logic [NUM_ELEM*ELEM_W-1:0] shuf_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] old_i,
  input  logic [NUM_ELEM-1:0]        act_i,
  input  logic [NUM_ELEM-1:0]        mask_i,
  input  logic                       mask_on_i,
  input  logic                       mask_en_i,
  input  logic                       zero_fill_i,
  input  logic                       tail_keep_i,
  output logic [NUM_ELEM*ELEM_W-1:0] res_o
);
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    logic                write;
    logic [ELEM_W-1:0]   held;
    assign write = !(mask_on_i && mask_en_i) || mask_i[e];
    // masked-off active element: merge keeps old, zero-fill clears
    assign held  = zero_fill_i ? '0 : old_i[e*ELEM_W +: ELEM_W];
    always_comb begin
      if (act_i[e])         res_o[e*ELEM_W +: ELEM_W] = write ? shuf_i[e*ELEM_W +: ELEM_W] : held;
      else if (tail_keep_i) res_o[e*ELEM_W +: ELEM_W] = old_i[e*ELEM_W +: ELEM_W];
      else                  res_o[e*ELEM_W +: ELEM_W] = '0;
    end
  end
endmodule

// File: rtl/pair_shuffle_unit.sv
module pair_shuffle_unit
  import pshuf_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 64,
  localparam int DATA_W  = NUM_ELEM * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        len_i,
  input  logic              bcast_i,
  input  logic              mask_en_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic [NUM_ELEM-1:0] imm_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] old_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic [NUM_ELEM-1:0] act;
  logic                tail_keep, mask_on, bcast_on, src1_old;
  logic [DATA_W-1:0]   src_a, src_b, shuf, res_d;

  pshuf_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
    .mode_i      (mode_i),
    .len_i       (len_i),
    .act_o       (act),
    .tail_keep_o (tail_keep),
    .mask_on_o   (mask_on),
    .bcast_on_o  (bcast_on),
    .src1_old_o  (src1_old)
  );

  assign src_a = src1_old ? old_i : src1_i;
  assign src_b = (bcast_on && bcast_i) ? {NUM_ELEM{src2_i[ELEM_W-1:0]}} : src2_i;

  pshuf_select #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_sel (
    .a_i    (src_a),
    .b_i    (src_b),
    .sel_i  (imm_i),
    .shuf_o (shuf)
  );

  pshuf_finish #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_fin (
    .shuf_i      (shuf),
    .old_i       (old_i),
    .act_i       (act),
    .mask_i      (mask_i),
    .mask_on_i   (mask_on),
    .mask_en_i   (mask_en_i),
    .zero_fill_i (mode_i == MODE_ZERO),
    .tail_keep_i (tail_keep),
    .res_o       (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/pshuf_chk.sv
module pshuf_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [1:0]   mode_i,
  input logic [1:0]   len_i,
  input logic         mask_en_i,
  input logic [7:0]   mask_i,
  input logic [511:0] old_i,
  input logic         valid_o,
  input logic [511:0] res_o
);
  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));
  // R7
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1] && len_i == 2'd0) |=> (res_o[511:128] == '0));
  // R9
  legacy_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0) |=> (res_o[511:128] == $past(old_i[511:128])));
  // R6
  zero_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3 && mask_en_i && !mask_i[0]) |=> (res_o[63:0] == '0));
  // R5
  merge_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && mask_en_i && !mask_i[1]) |=> (res_o[127:64] == $past(old_i[127:64])));
  // R8
  plain_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd1 && len_i == 2'd1) |=> (res_o[511:256] == $past(old_i[511:256])));
endmodule

bind pair_shuffle_unit pshuf_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .len_i     (len_i),
  .mask_en_i (mask_en_i),
  .mask_i    (mask_i),
  .old_i     (old_i),
  .valid_o   (valid_o),
  .res_o     (res_o)
);

// File: tb/sim_pair_shuffle_unit.sv
module sim_pair_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = '0, len_i = '0;
  logic         bcast_i = 1'b0, mask_en_i = 1'b0;
  logic [7:0]   mask_i = '0, imm_i = '0;
  logic [511:0] src1_i = '0, src2_i = '0, old_i = '0;
  logic         valid_o;
  logic [511:0] res_o;
  int           n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pair_shuffle_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i), .len_i(len_i),
    .bcast_i(bcast_i), .mask_en_i(mask_en_i), .mask_i(mask_i), .imm_i(imm_i),
    .src1_i(src1_i), .src2_i(src2_i), .old_i(old_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [511:0] model(logic [1:0] m, logic [1:0] l, logic bc, logic men,
      logic [7:0] mk, logic [7:0] im, logic [511:0] s1, logic [511:0] s2, logic [511:0] od);
    logic [511:0] a, b, r;
    int n;
    logic keep;
    n    = (m == 2'd0 || l == 2'd0) ? 2 : (l == 2'd1 ? 4 : 8);
    a    = (m == 2'd0) ? od : s1;
    b    = (m[1] && bc) ? {8{s2[63:0]}} : s2;
    keep = (m == 2'd0) || (m == 2'd1 && l == 2'd1);
    for (int e = 0; e < 8; e++) begin
      int idx;
      logic [63:0] v;
      idx = (e / 2) * 2 + int'(im[e]);
      v = (e % 2 == 0) ? a[idx*64 +: 64] : b[idx*64 +: 64];
      if (e < n) begin
        if (m[1] && men && !mk[e]) v = (m == 2'd3) ? 64'd0 : od[e*64 +: 64];
      end else begin
        v = keep ? od[e*64 +: 64] : 64'd0;
      end
      r[e*64 +: 64] = v;
    end
    return r;
  endfunction

  function automatic logic [511:0] pat(logic [7:0] tag);
    logic [511:0] r;
    for (int e = 0; e < 8; e++) r[e*64 +: 64] = {tag, 8'(e), 48'h7FF8_0000_0001};
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(string req, logic [511:0] exp, logic exp_v);
    n_chk++;
    if (res_o !== exp || valid_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s: res=%h valid=%b expected res=%h valid=%b", req, res_o, valid_o, exp, exp_v);
    end
  endtask

  task automatic run(string req, logic [1:0] m, logic [1:0] l, logic bc, logic men,
      logic [7:0] mk, logic [7:0] im, logic [511:0] s1, logic [511:0] s2, logic [511:0] od);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; len_i = l; bcast_i = bc; mask_en_i = men;
    mask_i = mk; imm_i = im; src1_i = s1; src2_i = s2; old_i = od;
    @(negedge clk);
    check(req, model(m, l, bc, men, mk, im, s1, s2, od), 1'b1);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [511:0] a, b, o, last;
    void'($urandom(32'h5eed_1234));
    a = pat(8'hA1); b = pat(8'hB2); o = pat(8'hC3);
    #9;
    check("R10 reset", '0, 1'b0);
    rst_n = 1'b1;
    run("R1 imm 00",  2'd1, 2'd2, 0, 0, 8'h00, 8'h00, a, b, o);
    run("R1 imm ff",  2'd1, 2'd2, 0, 0, 8'h00, 8'hFF, a, b, o);
    run("R1 imm a5",  2'd1, 2'd2, 0, 0, 8'h00, 8'hA5, a, b, o);
    run("R2 upper imm ignored", 2'd3, 2'd0, 0, 0, 8'h00, 8'hFE, a, b, o);
    run("R2 len3 full", 2'd2, 2'd3, 0, 0, 8'h00, 8'h3C, a, b, o);
    run("R3 broadcast masked", 2'd2, 2'd2, 1, 0, 8'h00, 8'hAA, a, b, o);
    run("R3 broadcast ignored plain", 2'd1, 2'd2, 1, 0, 8'h00, 8'hAA, a, b, o);
    run("R4 mask disabled", 2'd2, 2'd2, 0, 0, 8'h00, 8'h96, a, b, o);
    run("R4 all set", 2'd3, 2'd2, 0, 1, 8'hFF, 8'h69, a, b, o);
    run("R5 merge", 2'd2, 2'd2, 1, 1, 8'h5A, 8'hF0, a, b, o);
    run("R6 zero",  2'd3, 2'd2, 1, 1, 8'h5A, 8'h0F, a, b, o);
    run("R7 tail zero 256", 2'd2, 2'd1, 0, 0, 8'h00, 8'h0A, a, b, o);
    run("R8 plain 128", 2'd1, 2'd0, 0, 1, 8'h00, 8'h03, a, b, o);
    run("R8 plain 256", 2'd1, 2'd1, 0, 1, 8'h00, 8'h05, a, b, o);
    run("R9 legacy", 2'd0, 2'd2, 1, 1, 8'h00, 8'h02, pat(8'hEE), b, o);
    // R10 hold: drop valid, change inputs, result must not move
    last = res_o;
    @(negedge clk);
    valid_i = 1'b0; src1_i = pat(8'h11); old_i = pat(8'h22); mode_i = 2'd3;
    @(negedge clk);
    check("R10 hold", last, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      run(m == 2'd0 ? "R9 random" : (m == 2'd1 ? "R8 random" : "R1 R5 R6 random"),
          m, 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
          rnd512(), rnd512(), rnd512());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule